// File: doc/BRIEF.md
# Multiplexed Amplifier Bias Calibration Sequencer

This block is a digital controller for a multi-electrode recording array. It sets the first-stage bias current of each site's amplifier from that site's measured statistics instead of from a worst-case budget. All sites share one low-noise measurement channel. A start pulse begins a scan. The sequencer selects each site in turn and enables the shared channel for the length of the scan. After each switch it waits a programmable settling time, then takes one digitized noise-envelope sample and one spike-amplitude sample.

The noise value is turned into an 8-bit bias code through a reciprocal law: a louder noise floor gives a smaller code, and the result is clamped between a floor and a ceiling. An optional override handles electrodes with large action potentials. When the spike amplitude exceeds a programmable multiple of the noise, the site is given a programmable low-power code, however quiet its noise floor is. Each code is written into a per-site register that drives that site's current DAC. The register keeps its value until a later scan rewrites it. A one-cycle done pulse marks the end of the scan. The bandwidth-setting second stage gets a single fixed code that is shared by all sites.

Top module: `bias_cal_seq`

## Requirements
- R1: After reset, `meas_en_o` and `done_o` are 0, and every site register reads `MAX_CODE` (255).
- R2: A `start_i` pulse while idle starts a scan. `site_sel_o` is 0 and `meas_en_o` is 1 in the next cycle. `meas_en_o` stays 1 until the last site is written and is 0 whenever no scan runs.
- R3: After each site switch, `meas_valid_i` is ignored for `settle_cycles_i + 1` cycles. It is accepted from the following cycle on.
- R4: Sites are visited in ascending order from 0 to `NUM_SITES-1`. The selection advances by exactly one, on the clock edge where a measurement is accepted.
- R5: Without override, the code written is `RECIP_K / noise` using integer division with `RECIP_K` = 16384. The result is clamped to the range [`MIN_CODE`=8, `MAX_CODE`=255]. A noise value of 0 gives `MAX_CODE`.
- R6: When `spike_en_i` is 1 and the spike amplitude is strictly greater than `spike_ratio_i` × noise, the code written is `low_code_i`.
- R7: A site's code is visible on `rd_code_o` (combinational read at `rd_addr_i`) after the accepting edge. It is held unchanged between scans until that site is rewritten.
- R8: `done_o` is 1 for exactly one cycle, the cycle right after the last site's code is written.
- R9: A `start_i` pulse during a scan has no effect on the site sequence or on the scan's end.
- R10: `stage2_bias_o` always equals `STAGE2_CODE` (96), independent of site and scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan request pulse |
| settle_cycles_i | input | SETTLE_W | Settling wait after each site switch |
| spike_en_i | input | 1 | Enables the large-spike override |
| spike_ratio_i | input | RATIO_W | Spike-to-noise multiple that triggers the override |
| low_code_i | input | CODE_W | Code assigned under override |
| meas_valid_i | input | 1 | Measurement sample present |
| meas_noise_i | input | MEAS_W | Noise-envelope value |
| meas_spike_i | input | MEAS_W | Spike-amplitude value |
| rd_addr_i | input | SITE_W | Register-file read address |
| site_sel_o | output | SITE_W | Site routed to the shared channel |
| meas_en_o | output | 1 | Shared channel enable (scan active) |
| done_o | output | 1 | End-of-scan pulse |
| rd_code_o | output | CODE_W | Bias code of site `rd_addr_i` |
| stage2_bias_o | output | CODE_W | Common second-stage bias code |

## Verification
A start pulse given in one cycle shows up as `site_sel_o`=0 and `meas_en_o`=1 at the next edge. A site switch is followed by `settle_cycles_i + 1` cycles in which the bench drives junk valid samples. The real sample then goes in, and one edge later the new code can be read and the selection has moved on. After the last site, `done_o` is high in that same cycle. The bench drives inputs on falling edges and reads outputs a moment later. It waits exactly those cycle counts before each check, so a sample taken too early or a site that advances too soon shows up as a wrong site number or a missing done pulse.

// File: rtl/bias_cal_pkg.sv
package bias_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2
    } cal_state_e;
endpackage

// File: rtl/bias_code_map.sv
module bias_code_map #(
    parameter int MEAS_W   = 12,
    parameter int CODE_W   = 8,
    parameter int RATIO_W  = 4,
    parameter int RECIP_K  = 16384,
    parameter int MIN_CODE = 8,
    parameter int MAX_CODE = 255
) (
    input  logic [MEAS_W-1:0]  noise_i,
    input  logic [MEAS_W-1:0]  spike_i,
    input  logic               spike_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [CODE_W-1:0]  low_code_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               ovr_o
);
    localparam int K_W   = $clog2(RECIP_K + 1);
    localparam int Q_W   = (K_W > MEAS_W) ? K_W : MEAS_W;
    localparam int THR_W = MEAS_W + RATIO_W;
    localparam logic [Q_W-1:0] K_VAL   = Q_W'(RECIP_K);
    localparam logic [Q_W-1:0] MIN_VAL = Q_W'(MIN_CODE);
    localparam logic [Q_W-1:0] MAX_VAL = Q_W'(MAX_CODE);

    logic [THR_W-1:0] thr_d;
    logic [Q_W-1:0]   quot_d;
    logic [CODE_W-1:0] recip_d;

    always_comb begin
        thr_d  = {{RATIO_W{1'b0}}, noise_i} * {{MEAS_W{1'b0}}, ratio_i};
        ovr_o  = spike_en_i && ({{RATIO_W{1'b0}}, spike_i} > thr_d);
        quot_d = '0;
        if (noise_i == '0) begin
            recip_d = CODE_W'(MAX_CODE);
        end else begin
            quot_d = K_VAL / Q_W'(noise_i);
            if (quot_d > MAX_VAL)      recip_d = CODE_W'(MAX_CODE);
            else if (quot_d < MIN_VAL) recip_d = CODE_W'(MIN_CODE);
            else                       recip_d = quot_d[CODE_W-1:0];
        end
        code_o = ovr_o ? low_code_i : recip_d;
    end
endmodule

// File: rtl/bias_reg_file.sv
module bias_reg_file #(
    parameter int NUM_SITES  = 64,
    parameter int CODE_W     = 8,
    parameter int RESET_CODE = 255,
    parameter int SITE_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SITE_W-1:0] waddr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic [SITE_W-1:0] raddr_i,
    output logic [CODE_W-1:0] rdata_o
);
    logic [CODE_W-1:0] regs_d [NUM_SITES];
    logic [CODE_W-1:0] regs_q [NUM_SITES];

    always_comb begin
        for (int i = 0; i < NUM_SITES; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i && (int'(waddr_i) < NUM_SITES)) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SITES; i++) begin
                regs_q[i] <= CODE_W'(RESET_CODE);
            end
        end else begin
            for (int i = 0; i < NUM_SITES; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_o = (int'(raddr_i) < NUM_SITES) ? regs_q[raddr_i] : '0;

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/bias_cal_seq.sv
module bias_cal_seq
    import bias_cal_pkg::*;
#(
    parameter int NUM_SITES   = 64,
    parameter int MEAS_W      = 12,
    parameter int CODE_W      = 8,
    parameter int RATIO_W     = 4,
    parameter int SETTLE_W    = 8,
    parameter int RECIP_K     = 16384,
    parameter int MIN_CODE    = 8,
    parameter int MAX_CODE    = 255,
    parameter int STAGE2_CODE = 96,
    parameter int SITE_W      = (NUM_SITES > 1) ? $clog2(NUM_SITES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic                spike_en_i,
    input  logic [RATIO_W-1:0]  spike_ratio_i,
    input  logic [CODE_W-1:0]   low_code_i,
    input  logic                meas_valid_i,
    input  logic [MEAS_W-1:0]   meas_noise_i,
    input  logic [MEAS_W-1:0]   meas_spike_i,
    input  logic [SITE_W-1:0]   rd_addr_i,
    output logic [SITE_W-1:0]   site_sel_o,
    output logic                meas_en_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   rd_code_o,
    output logic [CODE_W-1:0]   stage2_bias_o
);
    localparam logic [SITE_W-1:0] LAST_SITE = SITE_W'(NUM_SITES - 1);

    typedef struct packed {
        cal_state_e          st;
        logic [SITE_W-1:0]   site;
        logic [SETTLE_W-1:0] cnt;
        logic                done;
    } seq_t;

    seq_t s_d, s_q;
    logic              wr_en_d;
    logic [CODE_W-1:0] code_w;
    logic              ovr_w;

    bias_code_map #(
        .MEAS_W  (MEAS_W),
        .CODE_W  (CODE_W),
        .RATIO_W (RATIO_W),
        .RECIP_K (RECIP_K),
        .MIN_CODE(MIN_CODE),
        .MAX_CODE(MAX_CODE)
    ) map_i (
        .noise_i   (meas_noise_i),
        .spike_i   (meas_spike_i),
        .spike_en_i(spike_en_i),
        .ratio_i   (spike_ratio_i),
        .low_code_i(low_code_i),
        .code_o    (code_w),
        .ovr_o     (ovr_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wr_en_d  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_SETTLE;
                    s_d.site = '0;
                    s_d.cnt  = '0;
                end
            end
            ST_SETTLE: begin
                if (s_q.cnt == settle_cycles_i) s_d.st  = ST_WAIT;
                else                            s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_WAIT: begin
                if (meas_valid_i) begin
                    wr_en_d = 1'b1;
                    s_d.cnt = '0;
                    if (s_q.site == LAST_SITE) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.site = s_q.site + 1'b1;
                        s_d.st   = ST_SETTLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bias_reg_file #(
        .NUM_SITES (NUM_SITES),
        .CODE_W    (CODE_W),
        .RESET_CODE(MAX_CODE),
        .SITE_W    (SITE_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en_d),
        .waddr_i(s_q.site),
        .wdata_i(code_w),
        .raddr_i(rd_addr_i),
        .rdata_o(rd_code_o)
    );

    assign site_sel_o    = s_q.site;
    assign meas_en_o     = (s_q.st != ST_IDLE);
    assign done_o        = s_q.done;
    assign stage2_bias_o = CODE_W'(STAGE2_CODE);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    scan_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_en_o) |-> (site_sel_o == '0));

    // R4
    site_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en_o && $past(meas_en_o) && (site_sel_o != $past(site_sel_o)))
            |-> (site_sel_o == $past(site_sel_o) + 1'b1));

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SETTLE && meas_valid_i) |=> (site_sel_o == $past(site_sel_o)));

    // R9
    restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en_o && start_i && !meas_valid_i) |=> (site_sel_o == $past(site_sel_o)));

    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_d && !ovr_w) |-> (code_w >= CODE_W'(MIN_CODE) && code_w <= CODE_W'(MAX_CODE)));
endmodule

// File: tb/bias_cal_seq_tb_top.sv
module bias_cal_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 64;
    localparam int SW     = 6;
    localparam int K      = 16384;
    localparam int MINC   = 8;
    localparam int MAXC   = 255;
    localparam int STAGE2 = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] settle = '0;
    logic spike_en = 1'b0;
    logic [3:0] ratio = '0;
    logic [7:0] low_code = '0;
    logic meas_valid = 1'b0;
    logic [11:0] noise = '0;
    logic [11:0] spike = '0;
    logic [SW-1:0] rd_addr = '0;
    logic [SW-1:0] site_sel;
    logic meas_en, done;
    logic [7:0] rd_code, stage2;

    int n_chk = 0;
    int n_err = 0;
    int exp_q [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    bias_cal_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .settle_cycles_i(settle),
        .spike_en_i(spike_en), .spike_ratio_i(ratio), .low_code_i(low_code),
        .meas_valid_i(meas_valid), .meas_noise_i(noise), .meas_spike_i(spike),
        .rd_addr_i(rd_addr), .site_sel_o(site_sel), .meas_en_o(meas_en),
        .done_o(done), .rd_code_o(rd_code), .stage2_bias_o(stage2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(int nz, int sp, bit en, int rt, int low);
        int q;
        if (en && sp > rt * nz) return low;
        if (nz == 0) return MAXC;
        q = K / nz;
        if (q > MAXC) return MAXC;
        if (q < MINC) return MINC;
        return q;
    endfunction

    task automatic read_code(input int a, output int v);
        rd_addr = SW'(a);
        #1;
        v = int'(rd_code);
    endtask

    task automatic check_all(input string req);
        int v;
        for (int a = 0; a < N; a++) begin
            read_code(a, v);
            check(v == exp_q[a], req, v, exp_q[a]);
        end
    endtask

    task automatic run_scan(input int st, input bit en, input int rt, input int low,
                            input bit poke_start, input bit directed);
        int nz, sp, e, v;
        settle = 8'(st); spike_en = en; ratio = 4'(rt); low_code = 8'(low);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        check(meas_en == 1'b1, "R2 enable at scan start", int'(meas_en), 1);
        check(site_sel == '0, "R2 first site", int'(site_sel), 0);
        for (int s = 0; s < N; s++) begin
            // R7: code from the previous scan still held before rewrite
            read_code(s, v);
            check(v == exp_q[s], "R7 held code", v, exp_q[s]);
            if (directed && s < 6) begin
                case (s)
                    0: begin nz = 0;    sp = 0; end
                    1: begin nz = 1;    sp = 0; end
                    2: begin nz = 4095; sp = 0; end
                    3: begin nz = 100;  sp = 0; end
                    4: begin nz = 64;   sp = 64 * rt; end
                    default: begin nz = 64; sp = 64 * rt + 1; end
                endcase
            end else begin
                nz = $urandom_range(20, 3000);
                sp = $urandom_range(0, 4095);
            end
            meas_valid = 1'b1; noise = 12'd4000; spike = 12'd0;
            for (int c = 0; c <= st; c++) begin
                if (poke_start && s == 5 && c == 0) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            #1;
            check(site_sel == SW'(s), "R3 junk samples ignored while settling", int'(site_sel), s);
            check(meas_en == 1'b1, "R2 enable during scan", int'(meas_en), 1);
            meas_valid = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            meas_valid = 1'b1; noise = 12'(nz); spike = 12'(sp);
            @(negedge clk);
            meas_valid = 1'b0;
            e = exp_code(nz, sp, en, rt, low);
            exp_q[s] = e;
            read_code(s, v);
            if (en && sp > rt * nz) check(v == e, "R6 spike override code", v, e);
            else                    check(v == e, "R5 reciprocal code", v, e);
            if (s == N - 1) begin
                check(done == 1'b1, "R8 done after last write", int'(done), 1);
                check(meas_en == 1'b0, "R2 enable off after scan", int'(meas_en), 0);
                @(negedge clk); #1;
                check(done == 1'b0, "R8 done lasts one cycle", int'(done), 0);
                check(meas_en == 1'b0, "R9 no restart from mid-scan start", int'(meas_en), 0);
            end else begin
                check(site_sel == SW'(s + 1), "R4 ascending site step", int'(site_sel), s + 1);
                check(done == 1'b0, "R8 no early done", int'(done), 0);
            end
        end
        check(stage2 == 8'(STAGE2), "R10 fixed second-stage code", int'(stage2), STAGE2);
        check_all("R7 codes after scan");
        repeat (20) @(negedge clk);
        #1;
        check(meas_en == 1'b0, "R2 enable off while idle", int'(meas_en), 0);
        check(done == 1'b0, "R8 done quiet while idle", int'(done), 0);
        check_all("R7 codes held while idle");
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd1234);
        for (int a = 0; a < N; a++) exp_q[a] = MAXC;
        repeat (3) @(negedge clk);
        #1;
        check(meas_en == 1'b0, "R1 reset enable", int'(meas_en), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset codes");
        check(stage2 == 8'(STAGE2), "R10 fixed second-stage code", int'(stage2), STAGE2);
        run_scan(3, 1'b1, 3, 20, 1'b1, 1'b1);
        run_scan(0, 1'b0, 5, 30, 1'b0, 1'b1);
        run_scan(7, 1'b1, 1, 2, 1'b1, 1'b1);
        run_scan(2, 1'b1, 2, 40, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule